// File: doc/BRIEF.md
# Second-Stage Access Fault Checker

This block takes the outcome of an intermediate-to-physical address lookup and decides whether the access that triggered it may proceed. It looks at several inputs together: the permission bits the lookup returned, the memory type, the kind of access, whether the access was aligned, and whether the access is a descriptor fetch made by the first-stage table walker. From these it picks at most one fault and reports its type, a read/write indication and the lookup level.

The decision logic is combinational. It captures its result into registers one cycle after a valid strobe, and a one-cycle output valid pulse marks the update. Between strobes the registered result holds. The second stage can be switched off. It is on when either of two enable controls is set. When both are clear, every strobe yields a clean, fault-free result.

Top module: `s2_fault_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared to zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. Results captured on a strobe hold until the next strobe.
- R3: If both `stage_en_vm` and `stage_en_dc` are low, a strobe yields `fault_valid`=0 and `fault_kind`=00, whatever the other inputs are.
- R4: An unaligned (`is_aligned`=0) access to device memory (`mem_is_device`=1) that is neither an instruction fetch nor a walk fetch raises an alignment fault (`fault_kind`=01). Its `fault_is_write` equals 1 exactly when the access kind is a write. This check takes priority over every permission check.
- R5: An instruction fetch (`acc_kind`=00) that is not a walk fetch faults with `fault_kind`=10 when `perm_xn`=1. It is reported as a read (`fault_is_write`=0).
- R6: A data write (`acc_kind`=10) that is not a walk fetch faults with `fault_kind`=10 when the write permission bit `perm_ap[2]` is 0. It is reported with `fault_is_write`=1.
- R7: A data read (`acc_kind`=01), and every walk fetch (`walk_fetch`=1) of any access kind, faults with `fault_kind`=10 when the read permission bit `perm_ap[1]` is 0. It is reported with `fault_is_write`=0. A walk fetch ignores `perm_xn` and `perm_ap[2]`.
- R8: A walk fetch that passes its read check but targets device memory raises `fault_kind`=10 with `fault_is_write`=0 when `prot_walk_en`=1. With `prot_walk_en`=0 it raises no fault.
- R9: On a fault, `fault_level` equals the `level` input of the strobe. With no fault it is 0.
- R10: `fault_valid` is 1 exactly when `fault_kind` is not 00. A fault-free result has `fault_kind`=00 and `fault_is_write`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Lookup result present this cycle |
| perm_ap | input | 3 | Access-permission field; bit 1 read allowed, bit 2 write allowed, bit 0 unused |
| perm_xn | input | 1 | Execute-never |
| mem_is_device | input | 1 | 1 = device memory, 0 = normal memory |
| acc_kind | input | 2 | 00 instruction fetch, 01 data read, 10 data write |
| is_aligned | input | 1 | Access was naturally aligned |
| walk_fetch | input | 1 | Descriptor fetch on behalf of the first-stage walk |
| prot_walk_en | input | 1 | Protected-walk mode |
| stage_en_vm | input | 1 | Second-stage translation enable |
| stage_en_dc | input | 1 | Default-cacheable control (also enables the stage) |
| level | input | LVL_W | Lookup level of the result |
| out_valid | output | 1 | One-cycle pulse: registered result updated |
| fault_valid | output | 1 | Registered result is a fault |
| fault_kind | output | 2 | 00 none, 01 alignment, 10 permission |
| fault_is_write | output | 1 | Fault reported as a write |
| fault_level | output | LVL_W | Level of the faulting lookup |

## Verification
The hardest situations to reach are the ones where several fault causes hold at once. Only the highest-priority cause may show. Examples are an unaligned device write that also lacks write permission, or a walk fetch whose original kind is a write or fetch and that carries a cleared write bit or a set execute-never bit. The directed tasks set up these overlaps on purpose. One case has a walk fetch with only read permission on device memory, run once with protected-walk mode on and once with it off. Another has a disabled stage paired with inputs that would otherwise fault. In each case the bench checks that exactly the expected fault, or no fault, reaches the registered outputs.

// File: rtl/s2fc_pkg.sv
// Shared encodings for the second-stage fault checker.
// Assumes: acc_kind encodings 2'b11 are never driven (treated as a data read).
package s2fc_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_ALIGN = 2'd1,
        FK_PERM  = 2'd2
    } fault_kind_e;

    localparam int AP_RD_BIT = 1;
    localparam int AP_WR_BIT = 2;
endpackage

// File: rtl/s2fc_align.sv
// Alignment screen: flags unaligned data accesses to device memory.
// Assumes walk fetches are always aligned, so they are excluded.
module s2fc_align
    import s2fc_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      is_aligned,
    input  logic      is_device,
    input  logic      walk,
    output logic      align_fail,
    output logic      align_write
);
    // Combinational alignment decision and its direction.
    always_comb begin
        align_fail  = !is_aligned && is_device && (kind != ACC_FETCH) && !walk;
        align_write = (kind == ACC_WRITE);
    end
endmodule

// File: rtl/s2fc_perm.sv
// Permission screen: chooses which permission bit governs the access,
// then evaluates the protected-walk rule for walk fetches.
// Assumes perm_ap bit positions from the package.
module s2fc_perm
    import s2fc_pkg::*;
(
    input  acc_kind_e  kind,
    input  logic [2:0] ap,
    input  logic       xn,
    input  logic       walk,
    input  logic       is_device,
    input  logic       prot_en,
    output logic       perm_fail,
    output logic       perm_write,
    output logic       prot_fail
);
    logic unused_ap0;
    assign unused_ap0 = ap[0];

    // Select the governing permission bit and report direction.
    always_comb begin
        perm_write = 1'b0;
        if (!walk && kind == ACC_FETCH) begin
            perm_fail = xn;
        end else if (!walk && kind == ACC_WRITE) begin
            perm_fail  = !ap[AP_WR_BIT];
            perm_write = 1'b1;
        end else begin
            perm_fail = !ap[AP_RD_BIT];
        end
    end

    // Protected-walk rule, meaningful only when permission passed.
    always_comb begin
        prot_fail = walk && is_device && prot_en && !perm_fail;
    end
endmodule

// File: rtl/s2fc_result_reg.sv
// Result register: captures the chosen fault on each strobe and pulses
// out_valid one cycle later. Holds the result between strobes.
module s2fc_result_reg
    import s2fc_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  fault_kind_e      kind_d,
    input  logic             write_d,
    input  logic [LVL_W-1:0] level_d,
    output logic             out_valid,
    output logic             fault_valid,
    output fault_kind_e      fault_kind,
    output logic             fault_is_write,
    output logic [LVL_W-1:0] fault_level
);
    // Strobe delay and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            fault_valid    <= 1'b0;
            fault_kind     <= FK_NONE;
            fault_is_write <= 1'b0;
            fault_level    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                fault_valid    <= (kind_d != FK_NONE);
                fault_kind     <= kind_d;
                fault_is_write <= (kind_d != FK_NONE) && write_d;
                fault_level    <= (kind_d != FK_NONE) ? level_d : '0;
            end
        end
    end

    assert_valid_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(fault_kind) && $stable(fault_level) && $stable(fault_is_write)));
    assert_valid_matches_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid == (fault_kind != FK_NONE));
    assert_clean_when_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_valid |-> (!fault_is_write && fault_level == '0));
endmodule

// File: rtl/s2_fault_check.sv
// Second-stage access fault checker (top).
// Combines the alignment and permission screens in fixed priority:
// alignment, then permission, then protected walk; a disabled stage
// suppresses all. Result registered by s2fc_result_reg.
module s2_fault_check
    import s2fc_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       perm_ap,
    input  logic             perm_xn,
    input  logic             mem_is_device,
    input  logic [1:0]       acc_kind,
    input  logic             is_aligned,
    input  logic             walk_fetch,
    input  logic             prot_walk_en,
    input  logic             stage_en_vm,
    input  logic             stage_en_dc,
    input  logic [LVL_W-1:0] level,
    output logic             out_valid,
    output logic             fault_valid,
    output logic [1:0]       fault_kind,
    output logic             fault_is_write,
    output logic [LVL_W-1:0] fault_level
);
    acc_kind_e   kind;
    logic        stage_on;
    logic        align_fail, align_write;
    logic        perm_fail, perm_write, prot_fail;
    fault_kind_e kind_d;
    logic        write_d;
    fault_kind_e kind_q;

    assign kind     = acc_kind_e'(acc_kind);
    assign stage_on = stage_en_vm || stage_en_dc;

    s2fc_align u_align (
        .kind        (kind),
        .is_aligned  (is_aligned),
        .is_device   (mem_is_device),
        .walk        (walk_fetch),
        .align_fail  (align_fail),
        .align_write (align_write)
    );

    s2fc_perm u_perm (
        .kind       (kind),
        .ap         (perm_ap),
        .xn         (perm_xn),
        .walk       (walk_fetch),
        .is_device  (mem_is_device),
        .prot_en    (prot_walk_en),
        .perm_fail  (perm_fail),
        .perm_write (perm_write),
        .prot_fail  (prot_fail)
    );

    // Priority select of the single reported fault.
    always_comb begin
        kind_d  = FK_NONE;
        write_d = 1'b0;
        if (stage_on) begin
            if (align_fail) begin
                kind_d  = FK_ALIGN;
                write_d = align_write;
            end else if (perm_fail) begin
                kind_d  = FK_PERM;
                write_d = perm_write;
            end else if (prot_fail) begin
                kind_d  = FK_PERM;
                write_d = 1'b0;
            end
        end
    end

    s2fc_result_reg #(.LVL_W(LVL_W)) u_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .kind_d         (kind_d),
        .write_d        (write_d),
        .level_d        (level),
        .out_valid      (out_valid),
        .fault_valid    (fault_valid),
        .fault_kind     (kind_q),
        .fault_is_write (fault_is_write),
        .fault_level    (fault_level)
    );
    assign fault_kind = kind_q;

    assert_disabled_no_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stage_en_vm && !stage_en_dc) |=> !fault_valid);
    assert_align_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stage_on && !is_aligned && mem_is_device && !walk_fetch
         && acc_kind != 2'd0) |=> (fault_kind == 2'd1));
    assert_xn_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stage_on && acc_kind == 2'd0 && !walk_fetch && perm_xn)
        |=> (fault_kind == 2'd2 && !fault_is_write));
    assert_write_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stage_on && acc_kind == 2'd2 && !walk_fetch && !perm_ap[2]
         && (is_aligned || !mem_is_device)) |=> (fault_kind == 2'd2 && fault_is_write));
    assert_walk_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stage_on && walk_fetch && !perm_ap[1])
        |=> (fault_kind == 2'd2 && !fault_is_write));
    assert_prot_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stage_on && walk_fetch && mem_is_device && prot_walk_en)
        |=> (fault_kind == 2'd2 && !fault_is_write));
    assert_level_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stage_on && walk_fetch && !perm_ap[1]) |=> (fault_level == $past(level)));
endmodule

// File: tb/tb_s2_fault_check.sv
`timescale 1ns/1ps
module tb_s2_fault_check;
    localparam int LVL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [2:0]       perm_ap;
    logic             perm_xn, mem_is_device, is_aligned, walk_fetch;
    logic             prot_walk_en, stage_en_vm, stage_en_dc;
    logic [1:0]       acc_kind;
    logic [LVL_W-1:0] level;
    logic             out_valid, fault_valid, fault_is_write;
    logic [1:0]       fault_kind;
    logic [LVL_W-1:0] fault_level;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    s2_fault_check #(.LVL_W(LVL_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .perm_ap(perm_ap),
        .perm_xn(perm_xn), .mem_is_device(mem_is_device), .acc_kind(acc_kind),
        .is_aligned(is_aligned), .walk_fetch(walk_fetch), .prot_walk_en(prot_walk_en),
        .stage_en_vm(stage_en_vm), .stage_en_dc(stage_en_dc), .level(level),
        .out_valid(out_valid), .fault_valid(fault_valid), .fault_kind(fault_kind),
        .fault_is_write(fault_is_write), .fault_level(fault_level)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one strobe at a falling edge, sample one cycle later at a falling edge.
    task automatic send(input logic [1:0] k, input logic [2:0] ap, input logic xn,
                        input logic dev, input logic al, input logic wk,
                        input logic pw, input logic vm, input logic dc,
                        input logic [LVL_W-1:0] lv);
        @(negedge clk);
        in_valid = 1'b1; acc_kind = k; perm_ap = ap; perm_xn = xn;
        mem_is_device = dev; is_aligned = al; walk_fetch = wk;
        prot_walk_en = pw; stage_en_vm = vm; stage_en_dc = dc; level = lv;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input int fk, input int wr, input int lv);
        check({req, " out_valid"}, int'(out_valid), 1);
        check({req, " fault_valid"}, int'(fault_valid), int'(fk != 0));
        check({req, " fault_kind"}, int'(fault_kind), fk);
        check({req, " fault_is_write"}, int'(fault_is_write), wr);
        check({req, " fault_level"}, int'(fault_level), lv);
    endtask

    task automatic t_reset_R1;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 fault_valid", int'(fault_valid), 0);
        check("R1 fault_kind", int'(fault_kind), 0);
        check("R1 fault_level", int'(fault_level), 0);
    endtask

    task automatic t_pulse_hold_R2;
        send(2'd1, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3);
        @(negedge clk);
        check("R2 out_valid drops", int'(out_valid), 0);
        check("R2 kind holds", int'(fault_kind), 2);
        check("R2 level holds", int'(fault_level), 3);
    endtask

    task automatic t_disabled_R3;
        send(2'd2, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
        expect_res("R3 disabled", 0, 0, 0);
        send(2'd0, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1);
        expect_res("R3 disabled walk", 0, 0, 0);
    endtask

    task automatic t_align_R4;
        send(2'd2, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
        expect_res("R4 unaligned dev write", 1, 1, 2);
        send(2'd1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1);
        expect_res("R4 unaligned dev read", 1, 0, 1);
        send(2'd0, 3'b110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1);
        expect_res("R4 fetch exempt", 0, 0, 0);
        send(2'd1, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1);
        expect_res("R4 normal exempt", 0, 0, 0);
    endtask

    task automatic t_fetch_R5;
        send(2'd0, 3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3);
        expect_res("R5 xn fetch", 2, 0, 3);
        send(2'd0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3);
        expect_res("R5 fetch ok no rw", 0, 0, 0);
    endtask

    task automatic t_write_R6;
        send(2'd2, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
        expect_res("R6 write denied", 2, 1, 2);
        send(2'd2, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
        expect_res("R6 write allowed", 0, 0, 0);
    endtask

    task automatic t_read_walk_R7;
        send(2'd1, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1);
        expect_res("R7 read denied", 2, 0, 1);
        send(2'd2, 3'b010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2);
        expect_res("R7 walk write kind read ok", 0, 0, 0);
        send(2'd0, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2);
        expect_res("R7 walk ignores xn", 0, 0, 0);
        send(2'd2, 3'b100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3);
        expect_res("R7 walk write kind read denied", 2, 0, 3);
    endtask

    task automatic t_prot_R8;
        send(2'd1, 3'b010, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2);
        expect_res("R8 prot walk device", 2, 0, 2);
        send(2'd1, 3'b010, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2);
        expect_res("R8 prot off", 0, 0, 0);
        send(2'd1, 3'b010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2);
        expect_res("R8 non-walk device", 0, 0, 0);
    endtask

    task automatic t_level_R9_R10;
        send(2'd1, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
        expect_res("R9 level zero fault", 2, 0, 0);
        send(2'd1, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3);
        expect_res("R10 clean result", 0, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; perm_ap = '0; perm_xn = 1'b0;
        mem_is_device = 1'b0; acc_kind = '0; is_aligned = 1'b1; walk_fetch = 1'b0;
        prot_walk_en = 1'b0; stage_en_vm = 1'b0; stage_en_dc = 1'b0; level = '0;
        repeat (3) @(negedge clk);
        t_reset_R1();
        rst_n = 1'b1;
        t_pulse_hold_R2();
        t_disabled_R3();
        t_align_R4();
        t_fetch_R5();
        t_write_R6();
        t_read_walk_R7();
        t_prot_R8();
        t_level_R9_R10();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule